// File: doc/BRIEF.md
# FM Channel Output Accumulator

This block turns the operator samples of a six-channel, four-operator FM synthesizer into one signed sample per channel for a 9-bit DAC. Operator samples arrive as a valid/ready stream, one slot at a time. Each channel sends its four slots in a fixed order, and the channels follow in a round-robin of six. With each slot comes the channel's 3-bit algorithm number. The algorithm decides whether that slot is a carrier. A carrier sample is signed and 14 bits wide. It is shifted right arithmetically by 5 before it is added, which reduces it to the 9-bit domain. The channel sum is then clamped to the asymmetric range -256..+256.

The finished channel sample leaves through a second valid/ready stream, together with the index of its channel. Back-pressure works as follows. While `out_valid` is high and `out_ready` is low, the output sample and channel index stay frozen and `in_ready` is low, so no slot is taken. When the output is empty, or is being taken in the same cycle, `in_ready` is high.

There is also a direct sample mode. When `dac_en` is set, the sixth channel's output is replaced by an 8-bit offset-binary value written through `dac_we`/`dac_data`. A ready flag reports when a written value has been consumed.

Top module: `fm_chan_accum`

## Requirements
- R1: After reset `out_valid` is 0, `in_ready` is 1, `dac_ready` is 1, and the first channel produced carries index 0.
- R2: A carrier slot contributes floor(x/32) of its sample x, with the sign preserved. So +8168 gives +255, -8168 gives -256, -1 gives -1 and +31 gives 0.
- R3: Slots are numbered 0..3 in arrival order. Slot 3 is a carrier for every algorithm. Under algorithm 4, slot 1 is also a carrier. Under algorithms 5 and 6, slots 1 and 2 are also carriers. Under algorithm 7, all four slots are carriers. Non-carrier slots have no effect on the output.
- R4: The sum of the shifted carriers is clamped to -256..+256 and never wraps. A value of +256 can only arise from two or more carriers.
- R5: `out_valid` rises in the cycle after the fourth slot of a channel is accepted. `out_chan` counts 0,1,2,3,4,5,0,…, one step per channel.
- R6: While `out_valid` is 1 and `out_ready` is 0, the output holds its data and `in_ready` is 0. Otherwise `in_ready` is 1.
- R7: With `dac_en` at 1, the output for channel index 5 is 2·(d−128), where d is the value last written. The FM slots of that channel are still consumed but have no effect.
- R8: A write (`dac_we`) drops `dac_ready` in the next cycle. `dac_ready` returns to 1 when a channel-5 output taken from the written value is transferred. A second write before that transfer replaces the pending value.
- R9: With `dac_en` at 0, channel 5 is summed like any other channel, and `dac_ready` does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operator slot sample present |
| in_ready | output | 1 | Slot is accepted this cycle if valid |
| in_sample | input | 14 | Signed operator sample |
| in_algo | input | 3 | Algorithm number of the current channel |
| out_valid | output | 1 | Channel sample present |
| out_ready | input | 1 | Consumer takes the channel sample |
| out_sample | output | 10 | Signed saturated channel sample |
| out_chan | output | 3 | Channel index 0..5 |
| dac_en | input | 1 | Replace channel 5 by the direct sample |
| dac_we | input | 1 | Write strobe for the direct sample |
| dac_data | input | 8 | Offset-binary direct sample |
| dac_ready | output | 1 | Last written sample has been consumed |

## Verification
The assertions check the handshake properties on every cycle: output data is held under stall, no slot is accepted while the output is blocked, the output stays within -256..+256 with a channel index below six, and `dac_ready` falls after every write. The arithmetic cannot be shown that way. The per-algorithm carrier choice, the floor behaviour of the shift, the clamp at both ends, the reach to +256 with two carriers, and the sample-register overwrite and consumption all depend on the bench's reference model and its directed scenarios.

// File: rtl/fm_acc_pkg.sv
package fm_acc_pkg;
  localparam int unsigned ALGO_W = 3;

  // Carrier table: the last slot always reaches the output.
  function automatic logic slot_is_carrier(input logic [ALGO_W-1:0] algo,
                                           input int unsigned slot);
    logic hit;
    hit = 1'b0;
    if (algo == 3'd7) hit = 1'b1;
    else if (slot == 3) hit = 1'b1;
    else if (algo == 3'd4) hit = (slot == 1);
    else if (algo == 3'd5 || algo == 3'd6) hit = (slot >= 1);
    return hit;
  endfunction
endpackage

// File: rtl/fm_carrier_sel.sv
module fm_carrier_sel
  import fm_acc_pkg::*;
#(
  parameter int unsigned SLOTS = 4
) (
  input  logic [ALGO_W-1:0] algo,
  output logic [SLOTS-1:0]  mask
);
  for (genvar i = 0; i < SLOTS; i++) begin : g_slot
    assign mask[i] = slot_is_carrier(algo, i);
  end
endmodule

// File: rtl/fm_slot_shift.sv
module fm_slot_shift #(
  parameter int unsigned IN_W  = 14,
  parameter int unsigned SHIFT = 5,
  parameter int unsigned ACC_W = 13
) (
  input  logic signed [IN_W-1:0]  din,
  input  logic                    keep,
  output logic signed [ACC_W-1:0] dout
);
  localparam int unsigned KEPT = IN_W - SHIFT;
  logic signed [ACC_W-1:0] ext;

  // Arithmetic shift: replicate the sign over the dropped bits.
  assign ext  = {{(ACC_W-KEPT){din[IN_W-1]}}, din[IN_W-1:SHIFT]};
  assign dout = keep ? ext : '0;
endmodule

// File: rtl/fm_sat.sv
module fm_sat #(
  parameter int unsigned ACC_W  = 13,
  parameter int unsigned OUT_W  = 10,
  parameter int          SAT_HI = 256,
  parameter int          SAT_LO = -256
) (
  input  logic signed [ACC_W-1:0] din,
  output logic signed [OUT_W-1:0] dout
);
  localparam logic signed [ACC_W-1:0] HI = ACC_W'(SAT_HI);
  localparam logic signed [ACC_W-1:0] LO = ACC_W'(SAT_LO);

  always_comb begin
    if (din > HI)      dout = OUT_W'(SAT_HI);
    else if (din < LO) dout = OUT_W'(SAT_LO);
    else               dout = din[OUT_W-1:0];
  end
endmodule

// File: rtl/fm_dac_reg.sv
module fm_dac_reg #(
  parameter int unsigned DAC_W = 8,
  parameter int unsigned OUT_W = 10
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    we,
  input  logic [DAC_W-1:0]        wdata,
  input  logic                    consume,
  output logic signed [OUT_W-1:0] value,
  output logic                    ready
);
  localparam logic [OUT_W-1:0] MID = OUT_W'(1 << (DAC_W - 1));
  logic [DAC_W-1:0] held_q;
  logic [OUT_W-1:0] centred;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held_q <= '0;
      ready  <= 1'b1;
    end else if (we) begin
      held_q <= wdata;
      ready  <= 1'b0;
    end else if (consume) begin
      ready  <= 1'b1;
    end
  end

  assign centred = {{(OUT_W-DAC_W){1'b0}}, held_q} - MID;
  assign value   = $signed({centred[OUT_W-2:0], 1'b0});
endmodule

// File: rtl/fm_chan_accum.sv
module fm_chan_accum #(
  parameter int unsigned IN_W   = 14,
  parameter int unsigned SHIFT  = 5,
  parameter int unsigned OUT_W  = 10,
  parameter int unsigned SLOTS  = 4,
  parameter int unsigned CHANS  = 6,
  parameter int unsigned DAC_W  = 8,
  parameter int          SAT_HI = 256,
  parameter int          SAT_LO = -256
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  output logic                    in_ready,
  input  logic signed [IN_W-1:0]  in_sample,
  input  logic [2:0]              in_algo,
  output logic                    out_valid,
  input  logic                    out_ready,
  output logic signed [OUT_W-1:0] out_sample,
  output logic [2:0]              out_chan,
  input  logic                    dac_en,
  input  logic                    dac_we,
  input  logic [DAC_W-1:0]        dac_data,
  output logic                    dac_ready
);
  localparam int unsigned SLOT_W = $clog2(SLOTS);
  localparam int unsigned CH_W   = $clog2(CHANS);
  localparam int unsigned ACC_W  = OUT_W + SLOT_W + 1;
  localparam logic [CH_W-1:0]   LAST_CH = CH_W'(CHANS - 1);
  localparam logic [SLOT_W-1:0] LAST_SL = SLOT_W'(SLOTS - 1);

  logic [SLOT_W-1:0]       slot_q;
  logic [CH_W-1:0]         chan_q;
  logic signed [ACC_W-1:0] acc_q, contrib, sum_next;
  logic signed [OUT_W-1:0] sat_val, dac_val;
  logic [SLOTS-1:0]        carrier;
  logic                    out_dac_q, accept, xfer, last_slot;

  fm_carrier_sel #(.SLOTS(SLOTS)) u_sel (.algo(in_algo), .mask(carrier));

  fm_slot_shift #(.IN_W(IN_W), .SHIFT(SHIFT), .ACC_W(ACC_W)) u_shift (
    .din(in_sample), .keep(carrier[slot_q]), .dout(contrib));

  assign sum_next = acc_q + contrib;

  fm_sat #(.ACC_W(ACC_W), .OUT_W(OUT_W), .SAT_HI(SAT_HI), .SAT_LO(SAT_LO)) u_sat (
    .din(sum_next), .dout(sat_val));

  fm_dac_reg #(.DAC_W(DAC_W), .OUT_W(OUT_W)) u_dac (
    .clk(clk), .rst_n(rst_n), .we(dac_we), .wdata(dac_data),
    .consume(xfer && out_dac_q), .value(dac_val), .ready(dac_ready));

  assign in_ready  = !out_valid || out_ready;
  assign accept    = in_valid && in_ready;
  assign xfer      = out_valid && out_ready;
  assign last_slot = (slot_q == LAST_SL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot_q     <= '0;
      chan_q     <= '0;
      acc_q      <= '0;
      out_valid  <= 1'b0;
      out_sample <= '0;
      out_chan   <= '0;
      out_dac_q  <= 1'b0;
    end else begin
      if (xfer) out_valid <= 1'b0;
      if (accept) begin
        if (last_slot) begin
          acc_q     <= '0;
          slot_q    <= '0;
          chan_q    <= (chan_q == LAST_CH) ? '0 : chan_q + 1'b1;
          out_valid <= 1'b1;
          out_chan  <= 3'(chan_q);
          if (chan_q == LAST_CH && dac_en) begin
            out_sample <= dac_val;
            out_dac_q  <= 1'b1;
          end else begin
            out_sample <= sat_val;
            out_dac_q  <= 1'b0;
          end
        end else begin
          acc_q  <= sum_next;
          slot_q <= slot_q + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/fm_chan_accum_chk.sv
module fm_chan_accum_chk #(
  parameter int unsigned OUT_W = 10
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    in_ready,
  input logic                    out_valid,
  input logic                    out_ready,
  input logic signed [OUT_W-1:0] out_sample,
  input logic [2:0]              out_chan,
  input logic                    dac_we,
  input logic                    dac_ready
);
  a_r6_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_sample) && $stable(out_chan)));

  a_r6_no_take_when_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);

  a_r4_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ($signed(out_sample) <= 256 && $signed(out_sample) >= -256));

  a_r5_chan_below_six: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_chan < 3'd6));

  a_r8_write_clears_ready: assert property (@(posedge clk) disable iff (!rst_n)
    dac_we |=> !dac_ready);
endmodule

bind fm_chan_accum fm_chan_accum_chk #(.OUT_W(OUT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_ready(in_ready), .out_valid(out_valid),
  .out_ready(out_ready), .out_sample(out_sample), .out_chan(out_chan),
  .dac_we(dac_we), .dac_ready(dac_ready));

// File: tb/fm_chan_accum_tb.sv
module fm_chan_accum_tb_top;
  logic              clk = 0;
  logic              rst_n = 0;
  logic              in_valid = 0;
  logic              in_ready;
  logic signed [13:0] in_sample = '0;
  logic [2:0]        in_algo = '0;
  logic              out_valid;
  logic              out_ready = 1;
  logic signed [9:0] out_sample;
  logic [2:0]        out_chan;
  logic              dac_en = 0;
  logic              dac_we = 0;
  logic [7:0]        dac_data = '0;
  logic              dac_ready;

  int total = 0, bad = 0, wd = 0, cyc = 0;
  int stall_mode = 0;
  bit started = 0;
  string cur_tag = "R2,R3";

  // reference model state
  int m_slot, m_chan, m_acc, m_samp, m_ochan, m_dac;
  bit m_valid, m_odac, m_dready;

  always #10 clk = ~clk;

  fm_chan_accum dut_i (.*);

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s at %0t: actual=%0d expected=%0d", tag, $time, act, exp);
    end
  endtask

  function automatic bit carrier(input int a, input int s);
    if (a == 7 || s == 3) return 1;
    if (a == 4) return s == 1;
    if (a == 5 || a == 6) return s >= 1;
    return 0;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_slot = 0; m_chan = 0; m_acc = 0; m_samp = 0; m_ochan = 0; m_dac = 0;
      m_valid = 0; m_odac = 0; m_dready = 1;
    end else begin
      bit rdy, take, xf;
      int c, t;
      rdy  = !(m_valid && !out_ready);
      take = in_valid && rdy;
      xf   = m_valid && out_ready;
      if (dac_we) m_dready = 0;
      else if (xf && m_odac) m_dready = 1;
      if (xf) m_valid = 0;
      if (take) begin
        c = carrier(in_algo, m_slot) ? (int'(in_sample) >>> 5) : 0;
        if (m_slot == 3) begin
          t = m_acc + c;
          if (t > 256) t = 256;
          if (t < -256) t = -256;
          if (m_chan == 5 && dac_en) begin
            m_samp = 2 * (m_dac - 128); m_odac = 1;
          end else begin
            m_samp = t; m_odac = 0;
          end
          m_ochan = m_chan; m_valid = 1;
          m_chan = (m_chan + 1) % 6; m_acc = 0; m_slot = 0;
        end else begin
          m_acc += c; m_slot++;
        end
      end
      if (dac_we) m_dac = dac_data;
    end
  end

  // per-cycle comparison, away from the edges
  always @(negedge clk) begin
    if (rst_n && started) begin
      #3;
      check(in_ready === !(m_valid && !out_ready), "R6", in_ready, !(m_valid && !out_ready));
      check(out_valid === m_valid, "R5", out_valid, m_valid);
      if (m_valid) begin
        check(int'(out_sample) == m_samp, cur_tag, out_sample, m_samp);
        check(int'(out_chan) == m_ochan, "R5", out_chan, m_ochan);
      end
      check(dac_ready === m_dready, "R8", dac_ready, m_dready);
    end
  end

  always @(negedge clk) begin
    cyc++;
    if (stall_mode == 0) out_ready = 1;
    else out_ready = ((cyc % 3) != 0) && ((cyc % 7) != 2);
  end

  always @(posedge clk) begin
    wd++;
    if (wd > 150000) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic send_slot(input int s, input int a);
    bit rdy;
    in_valid = 1; in_sample = 14'(s); in_algo = 3'(a);
    forever begin
      #1; rdy = in_ready;
      @(negedge clk);
      if (rdy) break;
    end
    in_valid = 0;
  endtask

  task automatic send_chan(input int a, input int s0, input int s1, input int s2, input int s3);
    send_slot(s0, a); send_slot(s1, a); send_slot(s2, a); send_slot(s3, a);
  endtask

  task automatic dac_write(input int d);
    dac_we = 1; dac_data = 8'(d);
    @(negedge clk);
    dac_we = 0;
  endtask

  int lf = 32'h1ace;
  function automatic int nxt();
    lf = (lf >> 1) ^ ((lf & 1) ? 32'hB400 : 0);
    return lf;
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    #3;
    // R1: reset state
    check(out_valid === 0, "R1", out_valid, 0);
    check(in_ready === 1, "R1", in_ready, 1);
    check(dac_ready === 1, "R1", dac_ready, 1);
    @(negedge clk);
    started = 1;

    // R2 and R3: shift and carrier selection
    cur_tag = "R2,R3";
    send_chan(0, 8000, -8000, 5000, 8168);   // 255
    send_chan(1, 100, 100, 100, -8168);      // -256
    send_chan(2, 8168, 8168, 8168, -1);      // -1
    send_chan(3, -8000, 0, 0, 31);           // 0
    send_chan(4, 8168, 3200, 8168, 3200);    // 200
    send_chan(5, -8168, 64, 64, 64);         // 6
    send_chan(6, 8168, -33, 0, 0);           // -2
    send_chan(7, 32, 32, 32, 32);            // 4

    // R4: saturation
    cur_tag = "R4";
    send_chan(7, 8168, 8168, 8168, 8168);    // clamp +256
    send_chan(7, -8168, -8168, -8168, -8168);// clamp -256
    send_chan(4, 0, 8168, 0, 8168);          // 510 -> 256
    send_chan(4, 0, -8168, 0, -8168);        // -512 -> -256
    send_chan(4, 0, 8168, 0, 32);            // exactly 256
    send_chan(5, 0, 8168, -8168, 8168);      // 254

    // R6: back-pressure
    cur_tag = "R6";
    stall_mode = 1;
    for (int i = 0; i < 12; i++)
      send_chan(nxt() % 8, (nxt() % 16337) - 8168, (nxt() % 16337) - 8168,
                (nxt() % 16337) - 8168, (nxt() % 16337) - 8168);
    stall_mode = 0;

    // R7 and R8: direct sample mode
    cur_tag = "R7";
    dac_en = 1;
    dac_write(8'h00);
    for (int i = 0; i < 6; i++) send_chan(7, 8168, 8168, 8168, 8168);
    dac_write(8'hFF);
    dac_write(8'h80);                        // R8: overwrite before use
    for (int i = 0; i < 6; i++) send_chan(0, 0, 0, 0, 8168);
    stall_mode = 1;
    dac_write(8'h01);
    for (int i = 0; i < 6; i++) send_chan(3, 0, 0, 0, -8168);
    stall_mode = 0;
    dac_write(8'hFF);
    for (int i = 0; i < 6; i++) send_chan(1, 0, 0, 0, 4000);

    // R9: mode off, channel 5 summed normally
    cur_tag = "R9";
    dac_en = 0;
    dac_write(8'h40);
    for (int i = 0; i < 6; i++) send_chan(7, 320, 320, 320, 320);

    // mixed traffic
    cur_tag = "R2,R3,R4,R7";
    for (int i = 0; i < 30; i++) begin
      stall_mode = i % 2;
      dac_en = (i % 3) == 0;
      if (i % 5 == 0) dac_write(nxt() % 256);
      send_chan(nxt() % 8, (nxt() % 16337) - 8168, (nxt() % 16337) - 8168,
                (nxt() % 16337) - 8168, (nxt() % 16337) - 8168);
    end
    stall_mode = 0;
    repeat (5) @(negedge clk);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule